// File: doc/BRIEF.md
# Bidirectional Gray Code Counter

This block is a synchronous counter whose state register holds a reflected Gray code. No binary count is stored and then converted. The next state comes straight from the present Gray value and a direction input. On each enabled clock edge the state moves one step forward or one step backward through the Gray sequence. Exactly one bit changes per step, including when the sequence wraps around.

The width is a parameter and may be 3 or 4 bits. A count enable freezes the state when it is low. An active-high synchronous reset returns the state to all zeros. The output is the Gray state itself, so a consumer can sample it with no glitch from more than one bit changing at once.

Top module: `gray_updown_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `gray_q` becomes all zeros after that edge, whatever `cnt_en` and `dir_up` are.
- R2: While `cnt_en` is low and `rst` is low, `gray_q` keeps its value across the clock edge, whatever `dir_up` is.
- R3: With WIDTH=3, `cnt_en`=1 and `dir_up`=1, successive edges take `gray_q` from 000 through 001, 011, 010, 110, 111, 101, 100 (bit 2 is the MSB).
- R4: With `cnt_en`=1 and `dir_up`=0, each edge moves `gray_q` to the code that precedes it in the up sequence, so down counting walks the same codes in reverse.
- R5: On every enabled edge with `rst` low, exactly one bit of `gray_q` differs from its value before the edge.
- R6: Counting up from the last code (MSB set, all other bits clear) gives all zeros.
- R7: Counting down from all zeros gives the last code (MSB set, all other bits clear).
- R8: With WIDTH=4, up counting follows the standard reflected Gray code, where step n is n XOR (n>>1), and 0000 follows 1000.
- R9: An up step followed by a down step returns `gray_q` to the code it held before the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, loads all zeros |
| cnt_en | input | 1 | Count enable; state holds when low |
| dir_up | input | 1 | 1 steps forward, 0 steps backward |
| gray_q | output | WIDTH | Present Gray code state |

## Verification
The assertions take `rst`, `cnt_en` and `dir_up` as known, not X or Z, at every rising edge. They take `rst` to be high at the first edge, so `gray_q` is defined from then on. The bench drives all three inputs only on falling edges, holds reset over the opening edges, and never leaves an input undriven. Because of that, every sampled value is settled and the one-bit-change and wrap properties always compare two defined states.

// File: rtl/gray_cnt_pkg.sv
package gray_cnt_pkg;

    localparam int GRAY_MIN_W = 3;
    localparam int GRAY_MAX_W = 4;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } gray_dir_e;

    typedef struct packed {
        logic      en;
        gray_dir_e dir;
    } step_ctl_t;

    function automatic step_ctl_t make_ctl(input logic en, input logic up);
        step_ctl_t c;
        c.en  = en;
        c.dir = up ? DIR_UP : DIR_DOWN;
        return c;
    endfunction

endpackage

// File: rtl/gray_step_logic.sv
module gray_step_logic
    import gray_cnt_pkg::*;
#(
    parameter int W = 3
) (
    input  logic [W-1:0] cur,
    input  gray_dir_e    dir,
    output logic [W-1:0] flip
);

    localparam logic [W-1:0] LSB_MASK = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

    logic [W:0]   seen;
    logic [W-1:0] low_oh;
    logic         parity;
    logic         take_lsb;
    logic         take_msb;

    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < W; i++) begin : g_low
            assign low_oh[i]  = cur[i] & ~seen[i];
            assign seen[i+1]  = seen[i] | cur[i];
        end
    endgenerate

    assign parity   = ^cur;
    assign take_lsb = (dir == DIR_UP) ? ~parity : parity;
    assign take_msb = low_oh[W-1] | ~seen[W];

    always_comb begin
        if (take_lsb) begin
            flip = LSB_MASK;
        end else begin
            flip = {low_oh[W-2:0], 1'b0};
            if (take_msb) begin
                flip = MSB_MASK;
            end
        end
    end

endmodule

// File: rtl/gray_state_reg.sv
module gray_state_reg
    import gray_cnt_pkg::*;
#(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  step_ctl_t    ctl,
    input  logic [W-1:0] flip,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (ctl.en) begin
            q <= q ^ flip;
        end
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (q == '0)); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!ctl.en) |=> $stable(q)); // R2

    AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (rst)
        ctl.en |=> ($countones(q ^ $past(q)) == 1)); // R5

endmodule

// File: rtl/gray_updown_counter.sv
module gray_updown_counter
    import gray_cnt_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             dir_up,
    output logic [WIDTH-1:0] gray_q
);

    localparam logic [WIDTH-1:0] LAST_CODE = {1'b1, {(WIDTH-1){1'b0}}};

    step_ctl_t        ctl;
    logic [WIDTH-1:0] flip;
    logic [WIDTH-1:0] state;

    initial begin
        if (WIDTH < GRAY_MIN_W || WIDTH > GRAY_MAX_W) begin
            $error("gray_updown_counter: WIDTH out of range");
        end
    end

    assign ctl = make_ctl(cnt_en, dir_up);

    gray_step_logic #(.W(WIDTH)) u_step (
        .cur  (state),
        .dir  (ctl.dir),
        .flip (flip)
    );

    gray_state_reg #(.W(WIDTH)) u_reg (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .flip (flip),
        .q    (state)
    );

    assign gray_q = state;

    AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && dir_up && gray_q == LAST_CODE) |=> (gray_q == '0)); // R6

    AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !dir_up && gray_q == '0) |=> (gray_q == LAST_CODE)); // R7

    AST_PARITY_TURN: assert property (@(posedge clk) disable iff (rst)
        cnt_en |=> ((^gray_q) != $past(^gray_q))); // R5

endmodule

// File: tb/sim_gray_updown_counter.sv
module sim_gray_updown_counter;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    // entry = {cnt_en, dir_up, expected 3-bit code after the edge}
    localparam logic [4:0] VEC [NVEC] = '{
        5'b11_001, 5'b11_011, 5'b11_010, 5'b11_110,
        5'b11_111, 5'b11_101, 5'b11_100, 5'b11_000,
        5'b00_000,
        5'b10_100, 5'b10_101, 5'b10_111, 5'b10_110,
        5'b10_010, 5'b10_011, 5'b10_001, 5'b10_000
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic       dir_up = 1'b1;
    logic [2:0] q3;
    logic [3:0] q4;

    int checks = 0;
    int failures = 0;
    int idx4 = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gray_updown_counter #(.WIDTH(3)) u0 (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .dir_up(dir_up), .gray_q(q3)
    );

    gray_updown_counter #(.WIDTH(4)) u1 (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .dir_up(dir_up), .gray_q(q4)
    );

    function automatic logic [3:0] g4(input int n);
        logic [3:0] b;
        b = 4'(n);
        return b ^ (b >> 1);
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // called at a falling edge; drives inputs, returns at the next falling edge
    task automatic step(input logic en, input logic up, input logic r);
        cnt_en = en;
        dir_up = up;
        rst    = r;
        @(negedge clk);
        if (r) idx4 = 0;
        else if (en) idx4 = up ? (idx4 + 1) % 16 : (idx4 + 15) % 16;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [2:0] prev3;
        logic [3:0] prev4;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset 3-bit", {1'b0, q3}, 4'b0000);
        check("R1 reset 4-bit", q4, 4'b0000);

        rst = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            prev3 = q3;
            step(VEC[i][4], VEC[i][3], 1'b0);
            check(VEC[i][4] ? (VEC[i][3] ? "R3 up step" : "R4 down step") : "R2 hold",
                  {1'b0, q3}, {1'b0, VEC[i][2:0]});
            check("R8 4-bit code", q4, g4(idx4));
            if (VEC[i][4]) check("R5 one bit", 4'($countones(q3 ^ prev3)), 4'd1);
        end

        // hold with down selected
        step(1'b0, 1'b0, 1'b0);
        check("R2 hold down", {1'b0, q3}, 4'b0000);

        // down wrap from zero
        step(1'b1, 1'b0, 1'b0);
        check("R7 down wrap 3-bit", {1'b0, q3}, 4'b0100);
        check("R7 down wrap 4-bit", q4, 4'b1000);

        // up wrap from last code
        step(1'b1, 1'b1, 1'b0);
        check("R6 up wrap 3-bit", {1'b0, q3}, 4'b0000);
        check("R6 up wrap 4-bit", q4, 4'b0000);

        // full 4-bit up walk, one bit per step
        for (int i = 0; i < 16; i++) begin
            prev4 = q4;
            step(1'b1, 1'b1, 1'b0);
            check("R8 4-bit up", q4, g4(idx4));
            check("R5 one bit 4-bit", 4'($countones(q4 ^ prev4)), 4'd1);
        end

        // reversal returns to prior code
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        prev3 = q3;
        prev4 = q4;
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        check("R9 reversal 3-bit", {1'b0, q3}, {1'b0, prev3});
        check("R9 reversal 4-bit", q4, prev4);

        // reset while enabled mid-run
        step(1'b1, 1'b1, 1'b1);
        check("R1 reset mid-run 3-bit", {1'b0, q3}, 4'b0000);
        check("R1 reset mid-run 4-bit", q4, 4'b0000);
        step(1'b1, 1'b1, 1'b0);
        check("R3 first step after reset", {1'b0, q3}, 4'b0001);

        finish_run();
    end

endmodule